// File: doc/BRIEF.md
# Watch-Style Real-Time-Clock Register Bank

This block is a byte-wide real-time-clock register bank that sits on a 32-bit system bus. It holds a binary calendar that advances once per tick: seconds, minutes, hours, weekday, day of month, month and two-digit year. Next to the calendar sit four control/status bytes, named A, B, C and D. Each has its own rule for which bits a write may change and which bits a read shows. Software selects a byte with four address bits. Reads are combinational. A byte from an odd-numbered slot comes back in bits [23:16] of the bus word, and a byte from an even-numbered slot comes back in bits [7:0].

Two side strobes let a system controller mark the clock contents as trusted or untrusted. Marking them trusted also forces the clock into its standard configuration. A separately loaded mode bit picks what the year slot reports. In fixed-year mode it reports the constant 82, which lets older software accept the clock. In standard mode it reports the running year counter.

Top module: `wclk_regbank`

## Requirements
- R1: The slot index is address bits [4:1]. Address bit 0 and the bits above bit 4 have no effect on reads or writes.
- R2: Reads return the calendar fields in binary: slot 0 seconds, slot 2 minutes, slot 4 hours, slot 6 weekday (0..6), slot 7 day of month (1..31), slot 8 month (0..11) and slot 9 year. Slots 1, 3, 5, 14 and 15 read as zero.
- R3: A read of an odd slot places the byte in rd_data[23:16] with every other bit zero. A read of an even slot places the byte in rd_data[7:0] with every other bit zero.
- R4: A write to slot 10 (register A) loads bits [6:0] from wr_data[6:0]. Bit 7 of A keeps its value. The weekday-independent divider field is A[6:4].
- R5: A write to slot 11 (register B) loads bits 0, 1, 2 and 7 from the written byte. Bits 3 to 6 keep their values. B[1] is the 24-hour flag and B[2] is the binary-data flag.
- R6: Register C (slot 12) ignores writes and reads as zero. Register D (slot 13) changes only bit 7 on a write, and a read of D shows only bit 7.
- R7: Writes to slots 0 to 9, 14 and 15 do not change any readable value.
- R8: A clock edge with rst_n low clears A, B, C and D to zero, selects fixed-year mode and loads the calendar with its start parameters.
- R9: mark_valid sets A[6:4] to 2 (it does not OR into the field), sets B[1] and B[2], and sets D[7]. mark_invalid clears only D[7] and wins over mark_valid in the same cycle. Both strobes apply after a bus write in the same cycle.
- R10: mode_wr loads the year mode from mode_std (1 = standard, 0 = fixed). In fixed mode slot 9 reads 82. In standard mode it reads the year counter.
- R11: Each cycle with tick high advances the seconds. Seconds and minutes wrap at 60, hours wrap at 24, and the weekday wraps from 6 to 0 at midnight. With tick low the calendar holds.
- R12: The day of month wraps after the length of the current month: 30 for months 3, 5, 8 and 10, 28 for month 1, or 29 when the year is a multiple of 4, and 31 for all other months. Month wraps from 11 to 0, and the year wraps from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| tick | input | 1 | One-second advance strobe |
| addr | input | ADDR_W | Bus address; slot index is addr[4:1] |
| wr_en | input | 1 | Write strobe for the addressed slot |
| wr_data | input | 8 | Write byte |
| rd_data | output | BUS_W | Lane-steered read word for the addressed slot |
| mark_valid | input | 1 | Mark contents trusted and force standard configuration |
| mark_invalid | input | 1 | Mark contents untrusted |
| mode_wr | input | 1 | Load the year mode |
| mode_std | input | 1 | Year mode value loaded by mode_wr |

## Verification
The embedded properties assume that tick, wr_en and both strobes are sampled clean on every rising edge, and that the calendar starts from a legal date so that its range checks hold from reset onward. The bench changes every input only on falling edges. It sets the start parameters of its three instances to legal dates next to a month end, a leap day and a year end. Because no bus path can load the calendar, these instances reach the rollover corners within a short tick run, and their outputs are compared against dates worked out by hand.

// File: rtl/wclk_pkg.sv
// Shared types, slot numbers and bit masks for the watch-style RTC bank.
// Assumes binary (not BCD) calendar storage throughout.
package wclk_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hr;
        byte_t dow;
        byte_t dom;
        byte_t mon;
        byte_t year;
    } cal_t;

    localparam int    SLOT_W   = 4;
    localparam byte_t SLOT_SEC = 8'd0;
    localparam byte_t SLOT_MIN = 8'd2;
    localparam byte_t SLOT_HR  = 8'd4;
    localparam byte_t SLOT_DOW = 8'd6;
    localparam byte_t SLOT_DOM = 8'd7;
    localparam byte_t SLOT_MON = 8'd8;
    localparam byte_t SLOT_YR  = 8'd9;
    localparam byte_t SLOT_A   = 8'd10;
    localparam byte_t SLOT_B   = 8'd11;
    localparam byte_t SLOT_C   = 8'd12;
    localparam byte_t SLOT_D   = 8'd13;

    localparam byte_t WMASK_A   = 8'h7F;
    localparam byte_t WMASK_B   = 8'h87;
    localparam byte_t VALID_BIT = 8'h80;
    localparam byte_t FMT_BITS  = 8'h06;
    localparam logic [2:0] DIV_STD = 3'd2;

    // Days in a month (month 0..11, binary year 0..99).
    function automatic byte_t month_len(input byte_t mon, input byte_t year);
        case (mon)
            8'd1:                     return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd3, 8'd5, 8'd8, 8'd10:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/wclk_calendar.sv
// Binary calendar counter advanced by a one-second tick.
// Assumes the start parameters form a legal date; carries ripple
// seconds -> minutes -> hours -> day/weekday -> month -> year in one cycle.
module wclk_calendar
    import wclk_pkg::*;
#(
    parameter int START_SEC  = 0,
    parameter int START_MIN  = 0,
    parameter int START_HR   = 0,
    parameter int START_DOW  = 0,
    parameter int START_DOM  = 1,
    parameter int START_MON  = 0,
    parameter int START_YEAR = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output cal_t cal
);

    localparam cal_t START_CAL = '{
        sec: 8'(START_SEC), min: 8'(START_MIN), hr: 8'(START_HR),
        dow: 8'(START_DOW), dom: 8'(START_DOM), mon: 8'(START_MON),
        year: 8'(START_YEAR)
    };

    cal_t nxt;

    // Next-state carry chain for one tick.
    always_comb begin
        nxt = cal;
        if (tick) begin
            if (cal.sec != 8'd59) nxt.sec = cal.sec + 8'd1;
            else begin
                nxt.sec = '0;
                if (cal.min != 8'd59) nxt.min = cal.min + 8'd1;
                else begin
                    nxt.min = '0;
                    if (cal.hr != 8'd23) nxt.hr = cal.hr + 8'd1;
                    else begin
                        nxt.hr  = '0;
                        nxt.dow = (cal.dow == 8'd6) ? 8'd0 : cal.dow + 8'd1;
                        if (cal.dom != month_len(cal.mon, cal.year)) nxt.dom = cal.dom + 8'd1;
                        else begin
                            nxt.dom = 8'd1;
                            if (cal.mon != 8'd11) nxt.mon = cal.mon + 8'd1;
                            else begin
                                nxt.mon  = '0;
                                nxt.year = (cal.year == 8'd99) ? 8'd0 : cal.year + 8'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // Calendar state register with power-up load.
    always_ff @(posedge clk) begin
        if (!rst_n) cal <= START_CAL;
        else        cal <= nxt;
    end

    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> cal == $past(cal)); // R11
    AST_CLOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cal.sec < 8'd60 && cal.min < 8'd60 && cal.hr < 8'd24 && cal.dow < 8'd7); // R11
    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cal.dom >= 8'd1 && cal.dom <= month_len(cal.mon, cal.year)
        && cal.mon < 8'd12 && cal.year < 8'd100); // R12

endmodule

// File: rtl/wclk_ctrl.sv
// Control bytes A..D and the year-mode bit.
// Assumes wr_en qualifies slot/wr_byte; strobes are applied after the
// bus write and mark_invalid has the last word on the valid bit.
module wclk_ctrl
    import wclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  byte_t             wr_byte,
    input  logic              mark_valid,
    input  logic              mark_invalid,
    input  logic              mode_wr,
    input  logic              mode_std,
    output byte_t             reg_a,
    output byte_t             reg_b,
    output byte_t             reg_c,
    output byte_t             reg_d,
    output logic              std_year
);

    byte_t a_n, b_n, d_n;

    // Register C never takes writes.
    assign reg_c = '0;

    // Masked writes followed by strobe overrides.
    always_comb begin
        a_n = reg_a;
        b_n = reg_b;
        d_n = reg_d;
        if (wr_en && slot == SLOT_A[SLOT_W-1:0]) a_n = (reg_a & ~WMASK_A) | (wr_byte & WMASK_A);
        if (wr_en && slot == SLOT_B[SLOT_W-1:0]) b_n = (reg_b & ~WMASK_B) | (wr_byte & WMASK_B);
        if (wr_en && slot == SLOT_D[SLOT_W-1:0]) d_n = (reg_d & ~VALID_BIT) | (wr_byte & VALID_BIT);
        if (mark_valid) begin
            a_n[6:4] = DIV_STD;
            b_n      = b_n | FMT_BITS;
            d_n      = d_n | VALID_BIT;
        end
        if (mark_invalid) d_n = d_n & ~VALID_BIT;
    end

    // Control byte registers, cleared at power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
            reg_d <= '0;
        end else begin
            reg_a <= a_n;
            reg_b <= b_n;
            reg_d <= d_n;
        end
    end

    // Year-mode bit, fixed-year after power-up.
    always_ff @(posedge clk) begin
        if (!rst_n)       std_year <= 1'b0;
        else if (mode_wr) std_year <= mode_std;
    end

    AST_A_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && slot == SLOT_A[SLOT_W-1:0] |=> reg_a[7] == $past(reg_a[7])); // R4
    AST_B_MID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && slot == SLOT_B[SLOT_W-1:0] |=> reg_b[6:3] == $past(reg_b[6:3])); // R5
    AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mark_valid && !mark_invalid |=> reg_a[6:4] == DIV_STD && reg_b[2:1] == 2'b11 && reg_d[7]); // R9
    AST_INVALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        mark_invalid |=> !reg_d[7] && reg_a == $past(a_n)); // R9
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> std_year == $past(mode_std)); // R10

endmodule

// File: rtl/wclk_regbank.sv
// Top of the watch-style RTC register bank: slot decode, read mux and
// lane steering around the calendar and control submodules.
// Assumes BUS_W >= LANE_SHIFT + 8 and ADDR_W > SLOT_LSB + SLOT_W.
module wclk_regbank
    import wclk_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BUS_W      = 32,
    parameter int LANE_SHIFT = 16,
    parameter int FIXED_YEAR = 82,
    parameter int START_SEC  = 0,
    parameter int START_MIN  = 0,
    parameter int START_HR   = 0,
    parameter int START_DOW  = 0,
    parameter int START_DOM  = 1,
    parameter int START_MON  = 0,
    parameter int START_YEAR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              mark_valid,
    input  logic              mark_invalid,
    input  logic              mode_wr,
    input  logic              mode_std
);

    localparam int SLOT_LSB = 1;
    localparam int SLOT_MSB = SLOT_LSB + SLOT_W - 1;

    logic [SLOT_W-1:0] slot;
    cal_t              cal;
    byte_t             reg_a, reg_b, reg_c, reg_d;
    logic              std_year;
    byte_t             rd_byte;
    logic              addr_unused;

    assign slot        = addr[SLOT_MSB:SLOT_LSB];
    assign addr_unused = ^{addr[0], addr[ADDR_W-1:SLOT_MSB+1]};

    wclk_calendar #(
        .START_SEC(START_SEC), .START_MIN(START_MIN), .START_HR(START_HR),
        .START_DOW(START_DOW), .START_DOM(START_DOM), .START_MON(START_MON),
        .START_YEAR(START_YEAR)
    ) cal_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cal(cal)
    );

    wclk_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot(slot), .wr_byte(wr_data),
        .mark_valid(mark_valid), .mark_invalid(mark_invalid),
        .mode_wr(mode_wr), .mode_std(mode_std),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
        .std_year(std_year)
    );

    // Byte selection for the addressed slot.
    always_comb begin
        case (8'(slot))
            SLOT_SEC: rd_byte = cal.sec;
            SLOT_MIN: rd_byte = cal.min;
            SLOT_HR:  rd_byte = cal.hr;
            SLOT_DOW: rd_byte = cal.dow;
            SLOT_DOM: rd_byte = cal.dom;
            SLOT_MON: rd_byte = cal.mon;
            SLOT_YR:  rd_byte = std_year ? cal.year : 8'(FIXED_YEAR);
            SLOT_A:   rd_byte = reg_a;
            SLOT_B:   rd_byte = reg_b;
            SLOT_C:   rd_byte = reg_c;
            SLOT_D:   rd_byte = reg_d & VALID_BIT;
            default:  rd_byte = '0;
        endcase
    end

    // Lane steering: odd slots move up to the upper half-word.
    assign rd_data = slot[0] ? (BUS_W'(rd_byte) << LANE_SHIFT) : BUS_W'(rd_byte);

    AST_ODD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        slot[0] |-> rd_data[LANE_SHIFT-1:0] == '0 && rd_data[BUS_W-1:LANE_SHIFT+8] == '0); // R3
    AST_EVEN_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot[0] |-> rd_data[BUS_W-1:8] == '0); // R3
    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 4'd1 || slot == 4'd3 || slot == 4'd5 || slot == 4'd14 || slot == 4'd15)
        |-> rd_data == '0); // R2
    AST_C_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_C[SLOT_W-1:0] |-> rd_data == '0); // R6

endmodule

// File: tb/wclk_regbank_tb_top.sv
`timescale 1ns/1ps
module wclk_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        mark_valid = 1'b0;
    logic        mark_invalid = 1'b0;
    logic        mode_wr = 1'b0;
    logic        mode_std = 1'b0;
    logic [31:0] rd_i, rd_y, rd_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    // Leap February, 23:59:58, Saturday (6).
    wclk_regbank #(.START_SEC(58), .START_MIN(59), .START_HR(23), .START_DOW(6),
                   .START_DOM(28), .START_MON(1), .START_YEAR(96)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_i), .mark_valid(mark_valid),
        .mark_invalid(mark_invalid), .mode_wr(mode_wr), .mode_std(mode_std));

    // Year end: 99, month 11, day 31, 23:59:58, weekday 2.
    wclk_regbank #(.START_SEC(58), .START_MIN(59), .START_HR(23), .START_DOW(2),
                   .START_DOM(31), .START_MON(11), .START_YEAR(99)) dut_y_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_y), .mark_valid(mark_valid),
        .mark_invalid(mark_invalid), .mode_wr(mode_wr), .mode_std(mode_std));

    // Non-leap February end: year 97.
    wclk_regbank #(.START_SEC(58), .START_MIN(59), .START_HR(23), .START_DOW(0),
                   .START_DOM(28), .START_MON(1), .START_YEAR(97)) dut_n_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_n), .mark_valid(mark_valid),
        .mark_invalid(mark_invalid), .mode_wr(mode_wr), .mode_std(mode_std));

    function automatic logic [31:0] lane(input int slot, input logic [7:0] b);
        return (slot % 2 == 1) ? {8'h00, b, 16'h0000} : {24'h0, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Which: 0 = dut_i, 1 = dut_y_i, 2 = dut_n_i.
    task automatic rd_chk(input string req, input int which, input logic [7:0] a,
                          input logic [31:0] exp);
        addr = a;
        #1;
        case (which)
            1:       chk(req, rd_y, exp);
            2:       chk(req, rd_n, exp);
            default: chk(req, rd_i, exp);
        endcase
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic v, input logic iv);
        @(negedge clk);
        mark_valid = v; mark_invalid = iv;
        @(negedge clk);
        mark_valid = 1'b0; mark_invalid = 1'b0;
    endtask

    task automatic set_mode(input logic s);
        @(negedge clk);
        mode_wr = 1'b1; mode_std = s;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R8 A clear", 0, 8'd20, lane(10, 8'h00));
        rd_chk("R8 B clear", 0, 8'd22, lane(11, 8'h00));
        rd_chk("R8 D clear", 0, 8'd26, lane(13, 8'h00));
        rd_chk("R8 R10 fixed year", 0, 8'd18, lane(9, 8'd82));
        rd_chk("R2 sec", 0, 8'd0, lane(0, 8'd58));
        rd_chk("R2 min", 0, 8'd4, lane(2, 8'd59));
        rd_chk("R2 hr", 0, 8'd8, lane(4, 8'd23));
        rd_chk("R2 dow", 0, 8'd12, lane(6, 8'd6));
        rd_chk("R2 R3 dom odd lane", 0, 8'd14, lane(7, 8'd28));
        rd_chk("R2 mon", 0, 8'd16, lane(8, 8'd1));
    endtask

    task automatic t_holes;
        rd_chk("R2 slot1", 0, 8'd2, 32'h0);
        rd_chk("R2 slot3", 0, 8'd6, 32'h0);
        rd_chk("R2 slot5", 0, 8'd10, 32'h0);
        rd_chk("R2 slot14", 0, 8'd28, 32'h0);
        rd_chk("R2 slot15", 0, 8'd30, 32'h0);
    endtask

    task automatic t_reg_a;
        bus_wr(8'd20, 8'hFF);
        rd_chk("R4 A top kept", 0, 8'd20, lane(10, 8'h7F));
        bus_wr(8'h95, 8'h35);
        rd_chk("R1 R4 A via aliased addr", 0, 8'hF5, lane(10, 8'h35));
        rd_chk("R1 sec via aliased addr", 0, 8'hE1, lane(0, 8'd58));
    endtask

    task automatic t_reg_b;
        bus_wr(8'd22, 8'hFF);
        rd_chk("R5 R3 B mask", 0, 8'd22, lane(11, 8'h87));
        bus_wr(8'd22, 8'h00);
        rd_chk("R5 B clear", 0, 8'd22, lane(11, 8'h00));
    endtask

    task automatic t_reg_cd;
        bus_wr(8'd24, 8'hFF);
        rd_chk("R6 C ignores write", 0, 8'd24, 32'h0);
        bus_wr(8'd26, 8'hFF);
        rd_chk("R6 D bit7 only", 0, 8'd26, lane(13, 8'h80));
        bus_wr(8'd26, 8'h7F);
        rd_chk("R6 D cleared", 0, 8'd26, 32'h0);
    endtask

    task automatic t_time_writes;
        bus_wr(8'd0, 8'h11);
        bus_wr(8'd14, 8'h05);
        bus_wr(8'd18, 8'h11);
        bus_wr(8'd28, 8'hAA);
        bus_wr(8'd2, 8'h22);
        rd_chk("R7 sec unchanged", 0, 8'd0, lane(0, 8'd58));
        rd_chk("R7 dom unchanged", 0, 8'd14, lane(7, 8'd28));
        rd_chk("R7 year unchanged", 0, 8'd18, lane(9, 8'd82));
        rd_chk("R7 slot14 still zero", 0, 8'd28, 32'h0);
        rd_chk("R7 slot1 still zero", 0, 8'd2, 32'h0);
        rd_chk("R7 A untouched", 0, 8'd20, lane(10, 8'h35));
    endtask

    task automatic t_strobes;
        bus_wr(8'd20, 8'h7F);
        bus_wr(8'd22, 8'h81);
        strobe(1'b1, 1'b0);
        rd_chk("R9 divider forced to 2", 0, 8'd20, lane(10, 8'h2F));
        rd_chk("R9 B format bits", 0, 8'd22, lane(11, 8'h87));
        rd_chk("R9 D valid", 0, 8'd26, lane(13, 8'h80));
        strobe(1'b0, 1'b1);
        rd_chk("R9 invalid clears D", 0, 8'd26, 32'h0);
        rd_chk("R9 invalid keeps A", 0, 8'd20, lane(10, 8'h2F));
        rd_chk("R9 invalid keeps B", 0, 8'd22, lane(11, 8'h87));
        bus_wr(8'd22, 8'h80);
        bus_wr(8'd20, 8'h0F);
        strobe(1'b1, 1'b1);
        rd_chk("R9 both: D stays clear", 0, 8'd26, 32'h0);
        rd_chk("R9 both: A divider set", 0, 8'd20, lane(10, 8'h2F));
        rd_chk("R9 both: B format set", 0, 8'd22, lane(11, 8'h86));
    endtask

    task automatic t_mode;
        set_mode(1'b1);
        rd_chk("R10 std year", 0, 8'd18, lane(9, 8'd96));
        rd_chk("R10 std year y", 1, 8'd18, lane(9, 8'd99));
        set_mode(1'b0);
        rd_chk("R10 back to fixed", 0, 8'd18, lane(9, 8'd82));
        set_mode(1'b1);
    endtask

    task automatic t_calendar;
        ticks(1);
        rd_chk("R11 sec advance", 0, 8'd0, lane(0, 8'd59));
        ticks(1);
        rd_chk("R11 sec wrap", 0, 8'd0, lane(0, 8'd0));
        rd_chk("R11 min wrap", 0, 8'd4, lane(2, 8'd0));
        rd_chk("R11 hr wrap", 0, 8'd8, lane(4, 8'd0));
        rd_chk("R11 dow 6->0", 0, 8'd12, lane(6, 8'd0));
        rd_chk("R12 leap day 29", 0, 8'd14, lane(7, 8'd29));
        rd_chk("R12 still Feb", 0, 8'd16, lane(8, 8'd1));
        rd_chk("R12 year wrap 99->0", 1, 8'd18, lane(9, 8'd0));
        rd_chk("R12 month wrap 11->0", 1, 8'd16, lane(8, 8'd0));
        rd_chk("R12 dom wrap 31->1", 1, 8'd14, lane(7, 8'd1));
        rd_chk("R11 dow y", 1, 8'd12, lane(6, 8'd3));
        rd_chk("R12 non-leap to March", 2, 8'd16, lane(8, 8'd2));
        rd_chk("R12 non-leap dom 1", 2, 8'd14, lane(7, 8'd1));
        ticks(60);
        rd_chk("R11 minute step", 0, 8'd4, lane(2, 8'd1));
        rd_chk("R11 sec after minute", 0, 8'd0, lane(0, 8'd0));
        ticks(86340);
        rd_chk("R12 leap Feb 29 -> Mar 1", 0, 8'd14, lane(7, 8'd1));
        rd_chk("R12 month to March", 0, 8'd16, lane(8, 8'd2));
        rd_chk("R11 dow next day", 0, 8'd12, lane(6, 8'd1));
        rd_chk("R11 midnight", 0, 8'd8, lane(4, 8'd0));
        rd_chk("R12 y second day", 1, 8'd14, lane(7, 8'd2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_holes();
        t_reg_a();
        t_reg_b();
        t_reg_cd();
        t_time_writes();
        t_strobes();
        t_mode();
        t_calendar();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule